// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by reading two levels of a page table from memory. The address is cut into three fields. The top field indexes an outer table whose byte address comes from a base input. The outer entry names the frame that holds an inner table. The middle field indexes that inner table. The inner entry gives the physical frame, and the low field is appended to it unchanged.

The walker takes one request at a time. It issues single-word reads on a plain request/acknowledge memory port, and the memory may take any number of cycles to answer. It returns the physical address, or one of three fault codes. The table base and table length are plain inputs, sampled when a request is accepted. Result caching and fault recovery belong to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, and mem_req and rsp_valid are 0.
- R2: The logical address splits as outer index = bits 31:20, inner index = bits 19:10 and page offset = bits 9:0.
- R3: The first read goes to byte address ptbr + 4 * outer index.
- R4: The second read goes to byte address (outer entry bits 31:10, followed by ten zero bits) + 4 * inner index.
- R5: A successful walk returns rsp_fault = 0, rsp_code = 0, and rsp_paddr = inner entry bits 31:10 followed by the page offset.
- R6: If the outer index is not less than ptlr, the response comes in the cycle after acceptance with code 1 and no memory read. Every fault sets rsp_fault = 1 and rsp_paddr = 0.
- R7: An outer entry with bit 0 clear ends the walk with code 2, and no inner read is made.
- R8: An inner entry with bit 0 clear ends the walk with code 3.
- R9: req_ready is 1 only while idle. req_valid asserted during a walk has no effect on reads or results.
- R10: rsp_valid is a single-cycle pulse for each accepted request, and req_ready returns to 1 in the next cycle.
- R11: mem_req is a single-cycle pulse for each read. At most one read is outstanding, and the next read or the response follows in the cycle after mem_ack.
- R12: The result does not depend on the memory latency, which can be one or more cycles after mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Logical address to translate |
| req_ready | output | 1 | Walker idle; a request is accepted this cycle |
| ptbr | input | 32 | Byte address of the outer table |
| ptlr | input | 13 | Number of valid outer entries |
| mem_req | output | 1 | One-cycle read request pulse |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_code | output | 2 | 0 ok, 1 length, 2 outer invalid, 3 inner invalid |
| rsp_paddr | output | 32 | Physical address (zero on fault) |

## Verification
A wrong walk state shows up at the ports within one cycle. A read pulse may come too early, too late or twice. An accepted request may be lost. req_ready may stay low after a result. A wrong latched index or wrong entry decoding first appears as a mismatched mem_addr on the read that follows, or as a wrong code or address on rsp_valid. The reference model predicts every port for every cycle, so any of these errors is reported in the cycle it first appears, not at the end of the walk.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_OUTER = 3'd1,
    ST_WT_OUTER = 3'd2,
    ST_RD_INNER = 3'd3,
    ST_WT_INNER = 3'd4,
    ST_DONE     = 3'd5
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LENGTH = 2'd1,
    FLT_OUTER  = 2'd2,
    FLT_INNER  = 2'd3
  } walk_fault_e;

endpackage

// File: rtl/pt_va_split.sv
// Cuts a logical address into outer index and low part; range-checks the outer index.
module pt_va_split #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 10,
  parameter int INNER_W = 10,
  localparam int OUTER_W = VA_W - OFF_W - INNER_W,
  localparam int LOW_W   = INNER_W + OFF_W
) (
  input  logic [VA_W-1:0]    vaddr,
  input  logic [OUTER_W:0]   tbl_len,
  output logic [OUTER_W-1:0] outer_idx,
  output logic [LOW_W-1:0]   low_bits,
  output logic               len_ok
);
  assign outer_idx = vaddr[VA_W-1:LOW_W];
  assign low_bits  = vaddr[LOW_W-1:0];
  assign len_ok    = {1'b0, outer_idx} < tbl_len;
endmodule

// File: rtl/pt_slot_addr.sv
// Byte address of an entry: table base plus index scaled by entry size.
module pt_slot_addr #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 12,
  parameter int SLOT_SH = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  assign addr = base + (ADDR_W'(idx) << SLOT_SH);
endmodule

// File: rtl/pt_entry_decode.sv
// Table entry fields: valid flag in bit 0, frame number in the upper bits.
module pt_entry_decode #(
  parameter int ENT_W = 32,
  parameter int OFF_W = 10,
  localparam int FRAME_W = ENT_W - OFF_W
) (
  input  logic [ENT_W-1:0]   entry,
  output logic               valid,
  output logic [FRAME_W-1:0] frame
);
  assign valid = entry[0];
  assign frame = entry[ENT_W-1:OFF_W];

  generate
    if (OFF_W > 1) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^entry[OFF_W-1:1];
    end
  endgenerate
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 10,
  parameter int INNER_W = 10,
  parameter int ENT_W   = 32,
  localparam int OUTER_W = VA_W - OFF_W - INNER_W,
  localparam int LOW_W   = INNER_W + OFF_W,
  localparam int FRAME_W = ENT_W - OFF_W,
  localparam int PA_W    = ENT_W,
  localparam int SLOT_SH = $clog2(ENT_W / 8)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               req_ready,
  input  logic [PA_W-1:0]    ptbr,
  input  logic [OUTER_W:0]   ptlr,
  output logic               mem_req,
  output logic [PA_W-1:0]    mem_addr,
  input  logic               mem_ack,
  input  logic [ENT_W-1:0]   mem_rdata,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [1:0]         rsp_code,
  output logic [PA_W-1:0]    rsp_paddr
);

  walk_state_e         state_q;
  logic [LOW_W-1:0]    low_q;
  logic                mem_req_q;
  logic [PA_W-1:0]     mem_addr_q;
  logic                rsp_valid_q;
  logic                rsp_fault_q;
  walk_fault_e         rsp_code_q;
  logic [PA_W-1:0]     rsp_paddr_q;

  logic [OUTER_W-1:0]  in_outer;
  logic [LOW_W-1:0]    in_low;
  logic                in_len_ok;
  logic [PA_W-1:0]     outer_slot;
  logic [PA_W-1:0]     inner_slot;
  logic                ent_valid;
  logic [FRAME_W-1:0]  ent_frame;
  logic [INNER_W-1:0]  inner_idx_q;
  logic [OFF_W-1:0]    offset_q;

  assign inner_idx_q = low_q[LOW_W-1:OFF_W];
  assign offset_q    = low_q[OFF_W-1:0];

  pt_va_split #(.VA_W(VA_W), .OFF_W(OFF_W), .INNER_W(INNER_W)) u_split (
    .vaddr    (req_vaddr),
    .tbl_len  (ptlr),
    .outer_idx(in_outer),
    .low_bits (in_low),
    .len_ok   (in_len_ok)
  );

  pt_slot_addr #(.ADDR_W(PA_W), .IDX_W(OUTER_W), .SLOT_SH(SLOT_SH)) u_outer_slot (
    .base(ptbr),
    .idx (in_outer),
    .addr(outer_slot)
  );

  pt_entry_decode #(.ENT_W(ENT_W), .OFF_W(OFF_W)) u_decode (
    .entry(mem_rdata),
    .valid(ent_valid),
    .frame(ent_frame)
  );

  pt_slot_addr #(.ADDR_W(PA_W), .IDX_W(INNER_W), .SLOT_SH(SLOT_SH)) u_inner_slot (
    .base({ent_frame, {OFF_W{1'b0}}}),
    .idx (inner_idx_q),
    .addr(inner_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      low_q       <= '0;
      mem_req_q   <= 1'b0;
      mem_addr_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_code_q  <= FLT_NONE;
      rsp_paddr_q <= '0;
    end else begin
      mem_req_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            low_q <= in_low;
            if (!in_len_ok) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_code_q  <= FLT_LENGTH;
              rsp_paddr_q <= '0;
              state_q     <= ST_DONE;
            end else begin
              mem_req_q  <= 1'b1;
              mem_addr_q <= outer_slot;
              state_q    <= ST_RD_OUTER;
            end
          end
        end
        ST_RD_OUTER: state_q <= ST_WT_OUTER;
        ST_WT_OUTER: begin
          if (mem_ack) begin
            if (ent_valid) begin
              mem_req_q  <= 1'b1;
              mem_addr_q <= inner_slot;
              state_q    <= ST_RD_INNER;
            end else begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_code_q  <= FLT_OUTER;
              rsp_paddr_q <= '0;
              state_q     <= ST_DONE;
            end
          end
        end
        ST_RD_INNER: state_q <= ST_WT_INNER;
        ST_WT_INNER: begin
          if (mem_ack) begin
            rsp_valid_q <= 1'b1;
            state_q     <= ST_DONE;
            if (ent_valid) begin
              rsp_fault_q <= 1'b0;
              rsp_code_q  <= FLT_NONE;
              rsp_paddr_q <= {ent_frame, offset_q};
            end else begin
              rsp_fault_q <= 1'b1;
              rsp_code_q  <= FLT_INNER;
              rsp_paddr_q <= '0;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = mem_req_q;
  assign mem_addr  = mem_addr_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = rsp_fault_q;
  assign rsp_code  = rsp_code_q;
  assign rsp_paddr = rsp_paddr_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int OUTER_W = 12,
  parameter int OFF_W   = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [OUTER_W-1:0] va_outer,
  input logic [OFF_W-1:0]   va_off,
  input logic               req_ready,
  input logic [OUTER_W:0]   ptlr,
  input logic               mem_req,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic [1:0]         rsp_code,
  input logic [OFF_W-1:0]   paddr_off
);

  logic [OFF_W-1:0] cap_off;

  always_ff @(posedge clk) begin
    if (rst) cap_off <= '0;
    else if (req_valid && req_ready) cap_off <= va_off;
  end

  AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10
  AST_READY_AFTER_RESULT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> req_ready); // R10
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_req && !rsp_valid)); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R9
  AST_LENGTH_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && ({1'b0, va_outer} >= ptlr)) |=> (rsp_valid && rsp_code == 2'd1)); // R6
  AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault == (rsp_code != 2'd0))); // R6
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (paddr_off == cap_off)); // R5

endmodule

bind pt_walker pt_walker_chk #(.OUTER_W(OUTER_W), .OFF_W(OFF_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .va_outer (req_vaddr[VA_W-1:VA_W-OUTER_W]),
  .va_off   (req_vaddr[OFF_W-1:0]),
  .req_ready(req_ready),
  .ptlr     (ptlr),
  .mem_req  (mem_req),
  .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault),
  .rsp_code (rsp_code),
  .paddr_off(rsp_paddr[OFF_W-1:0])
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_ready;
  logic [31:0] ptbr;
  logic [12:0] ptlr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;

  always #2.5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .ptbr(ptbr), .ptlr(ptlr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr)
  );

  logic [31:0] mem [int unsigned];
  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit reset_checked = 1'b0;

  // reference model state
  int          m_phase = 0;   // 0 idle, 1 outer read, 2 inner read, 3 result
  logic [31:0] m_va;
  logic [31:0] m_addr;
  logic [31:0] ent;
  bit          e_ready = 1'b1;
  bit          e_mreq = 1'b0;
  logic [31:0] e_maddr;
  string       e_atag = "R3";
  bit          e_rv = 1'b0;
  logic [1:0]  e_code;
  logic [31:0] e_paddr;
  string       e_tag = "R5";
  int          lat_cnt = 0;
  int          lat_pick = 1;
  logic [31:0] lat_addr;
  bit          fx_on = 1'b0;
  logic [31:0] fx_pa;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] va(input int o, input int i, input int f);
    return {o[11:0], i[9:0], f[9:0]};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", rq, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      if (!reset_checked && cyc == 0) begin
        chk(req_ready === 1'b1, "R1", "req_ready in reset", {31'b0, req_ready}, 32'd1);
        chk(mem_req === 1'b0, "R1", "mem_req in reset", {31'b0, mem_req}, 32'd0);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        reset_checked = 1'b1;
      end
      mem_ack = 1'b0;
      mem_rdata = 32'h0;
    end else begin
      cyc++;
      if (cyc > 50000) begin
        errors++;
        checks++;
        $display("FAIL watchdog R11 actual=%0d expected<%0d", cyc, 50000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
      // compare ports with the prediction made one cycle earlier
      chk(req_ready === e_ready, "R9", "req_ready", {31'b0, req_ready}, {31'b0, e_ready});
      chk(mem_req === e_mreq, "R11", "mem_req", {31'b0, mem_req}, {31'b0, e_mreq});
      if (e_mreq && mem_req)
        chk(mem_addr === e_maddr, e_atag, "mem_addr", mem_addr, e_maddr);
      chk(rsp_valid === e_rv, "R10", "rsp_valid", {31'b0, rsp_valid}, {31'b0, e_rv});
      if (e_rv && rsp_valid) begin
        chk(rsp_code === e_code, e_tag, "rsp_code", {30'b0, rsp_code}, {30'b0, e_code});
        chk(rsp_fault === (e_code != 2'd0), e_tag, "rsp_fault", {31'b0, rsp_fault},
            {31'b0, (e_code != 2'd0)});
        chk(rsp_paddr === e_paddr, e_tag, "rsp_paddr", rsp_paddr, e_paddr);
        if (fx_on) chk(rsp_paddr === fx_pa, "R2", "field split paddr", rsp_paddr, fx_pa);
      end
      // memory with latency cycling through 1..4 (R12)
      mem_ack = 1'b0;
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          mem_ack = 1'b1;
          mem_rdata = rd(lat_addr);
        end
      end
      if (mem_req) begin
        lat_cnt = lat_pick;
        lat_addr = mem_addr;
        lat_pick = (lat_pick % 4) + 1;
      end
      // predict the next cycle
      e_mreq = 1'b0;
      e_rv = 1'b0;
      case (m_phase)
        0: if (req_valid) begin
          m_va = req_vaddr;
          if ({1'b0, req_vaddr[31:20]} >= ptlr) begin
            e_rv = 1'b1; e_code = 2'd1; e_paddr = 32'h0; e_tag = "R6"; m_phase = 3;
          end else begin
            m_addr = ptbr + {18'b0, req_vaddr[31:20], 2'b00};
            e_mreq = 1'b1; e_maddr = m_addr; e_atag = "R3"; m_phase = 1;
          end
        end
        1: if (mem_ack) begin
          ent = rd(m_addr);
          if (!ent[0]) begin
            e_rv = 1'b1; e_code = 2'd2; e_paddr = 32'h0; e_tag = "R7"; m_phase = 3;
          end else begin
            m_addr = {ent[31:10], 10'b0} + {20'b0, m_va[19:10], 2'b00};
            e_mreq = 1'b1; e_maddr = m_addr; e_atag = "R4"; m_phase = 2;
          end
        end
        2: if (mem_ack) begin
          ent = rd(m_addr);
          e_rv = 1'b1;
          m_phase = 3;
          if (!ent[0]) begin
            e_code = 2'd3; e_paddr = 32'h0; e_tag = "R8";
          end else begin
            e_code = 2'd0; e_paddr = {ent[31:10], m_va[9:0]}; e_tag = "R5/R12";
          end
        end
        default: m_phase = 0;
      endcase
      e_ready = (m_phase == 0);
    end
  end

  task automatic issue(input logic [31:0] a, input int poke);
    @(posedge clk); #1;
    req_vaddr = a;
    req_valid = 1'b1;
    forever begin
      bit rdy;
      rdy = req_ready;
      @(posedge clk); #1;
      if (rdy) break;
    end
    if (poke > 0) begin
      req_vaddr = ~a;               // R9: must be ignored while busy
      repeat (poke) begin @(posedge clk); #1; end
    end
    req_valid = 1'b0;
    while (!rsp_valid) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  initial begin
    rst = 1'b1;
    req_valid = 1'b0;
    req_vaddr = 32'h0;
    ptbr = 32'h0001_0000;
    ptlr = 13'd8;
    mem_ack = 1'b0;
    mem_rdata = 32'h0;
    // outer table at 0x10000
    mem[32'h0001_0000] = 32'h0004_0001;  // outer 0 -> inner table 0x40000
    mem[32'h0001_0004] = 32'h0004_0000;  // outer 1 invalid
    mem[32'h0001_0008] = 32'h0008_0001;  // outer 2 -> 0x80000
    mem[32'h0001_001C] = 32'h000C_0001;  // outer 7 -> 0xC0000
    mem[32'h0004_000C] = 32'h000A_9401;  // frame 0x2A5
    mem[32'h0004_0014] = 32'h000A_9400;  // invalid inner
    mem[32'h0008_0FFC] = 32'hFFFF_FC01;  // largest frame
    mem[32'h000C_0000] = 32'h0000_0401;  // frame 1
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R2 R5: plain walk with explicit expected address
    fx_pa = 32'h000A_9555;
    fx_on = 1'b1;
    issue(va(0, 3, 32'h155), 0);
    fx_on = 1'b0;
    // R6: index equal to length faults; one below is walked
    issue(va(8, 0, 0), 0);
    issue(va(7, 0, 32'h2C), 0);
    // R7, R8
    issue(va(1, 3, 5), 0);
    issue(va(0, 5, 7), 0);
    // R4 R5: top inner slot and largest frame
    issue(va(2, 32'h3FF, 32'h3FF), 0);
    // R9: requests held during a walk are ignored
    issue(va(0, 3, 1), 2);
    issue(va(2, 32'h3FF, 0), 3);
    // R12: same walk under each latency
    for (int k = 0; k < 5; k++) issue(va(0, 3, k), 0);
    // R6: zero length and largest length
    ptlr = 13'd0;
    issue(va(0, 3, 0), 0);
    ptlr = 13'h1000;
    issue(va(32'hFFF, 0, 0), 0);
    issue(va(7, 0, 9), 0);
    // R3: moved table base
    ptbr = 32'h0001_0008;
    issue(va(0, 32'h3FF, 4), 0);
    repeat (5) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule